// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block holds the time of day and the calendar date and moves them forward once for every one-second tick. It keeps seconds, minutes, hours, day of week, date, month and a two-digit year. February gets its leap day. A control pin chooses the rendering: plain binary or packed BCD. A second control pin chooses 24-hour or 12-hour hours, and in 12-hour hours a PM flag rides along. An optional daylight-saving rule moves the hour forward in spring and back in autumn.

Software reads and writes the fields through a byte-wide register port. Time is kept internally in one canonical binary 24-hour form. The port converts every byte on the way in and on the way out, using the data-mode and hour-format pins as they stand at that moment. The register port is plain control access with no handshake: a write takes effect on the clock edge where `wr_en` is high, a read is combinational from `rd_addr`, and neither side can stall.

Register indices are: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 seconds alarm, 8 minutes alarm, 9 hours alarm. Each completed update raises a one-cycle end-of-update pulse. When the three alarm bytes match, the block also raises an alarm pulse.

Top module: `rtc_calendar_core`

## Requirements
- R1: Each accepted tick adds one to the seconds. Seconds wrap from 59 to 0 and carry into the minutes, minutes wrap from 59 to 0 and carry into the hours, and hours wrap from 23 to 0.
- R2: When the hours wrap, the block advances the day. Day of week runs 1..7, where 1 is Sunday, and wraps from 7 to 1. The date wraps to 1 after the last day of the month and carries into the month. The month wraps from 12 to 1 and carries into the year. The year wraps from 99 to 0.
- R3: February has 29 days when the year is divisible by 4, and 28 days otherwise.
- R4: With `data_binary`=1 every register byte, including the alarm bytes, is plain binary. With `data_binary`=0 it is packed BCD, with the tens digit in bits 7:4. For example, 45 seconds reads 0x2D in binary and 0x45 in BCD. The stored time does not depend on the mode.
- R5: With `hour24`=0, bit 7 of the hours byte is PM and bits 6:0 hold 12, 1..11. Hour 0 reads 0x12, hour 13 reads 0x81 in BCD, and a write of 0x92 stores noon.
- R6: While `set_inhibit`=1 a tick changes nothing and raises no pulse. A tick in a cycle with `wr_en`=1 is also dropped, and the written value stands.
- R7: `update_done` is high for exactly the one cycle in which the advanced time is first readable, and only after an accepted tick.
- R8: `alarm_hit` pulses together with `update_done` when each alarm byte either equals the current byte of its field or has bits 7:6 both 1, which makes that field a don't-care.
- R9: With `dst_en`=1 there are two seasonal jumps. On a Sunday in April with date 1..7, 01:59:59 is followed by 03:00:00. On a Sunday in October with date 25 or later, 01:59:59 is followed by 01:00:00 the first time, and by 02:00:00 the second time. With `dst_en`=0 neither jump happens.
- R10: After reset the time is 00:00:00, day of week 1, date 1, month 1, year 0, the alarm bytes are 0x00, and both pulses are low.
- R11: Reading an index from 10 to 15 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1s | input | 1 | One-cycle pulse per second |
| set_inhibit | input | 1 | Freezes advancing while 1 |
| data_binary | input | 1 | 1 binary, 0 BCD |
| hour24 | input | 1 | 1 for 24-hour, 0 for 12-hour with PM flag |
| dst_en | input | 1 | Enables daylight-saving jumps |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write index |
| wr_data | input | 8 | Write byte |
| rd_addr | input | 4 | Read index |
| rd_data | output | 8 | Read byte (combinational) |
| update_done | output | 1 | End-of-update pulse |
| alarm_hit | output | 1 | Alarm pulse |

## Verification
The assertions check the timing relations on every cycle:
- every accepted tick leads to an `update_done` pulse on the next cycle, and no pulse appears otherwise;
- `alarm_hit` never appears without `update_done`;
- seconds step by one or wrap;
- the time fields stay frozen under `set_inhibit`.

Only the bench scenarios can show the calendar carries, the leap rule, the byte renderings in each mode, the daylight-saving jumps and the alarm don't-care matching. Each of these depends on specific register contents that the scenarios set up.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int REG_AW  = 4;
  localparam int BYTE_W  = 8;
  localparam int VAL_W   = 7;
  localparam int SEC_W   = 6;
  localparam int HOUR_W  = 5;
  localparam int DOW_W   = 3;
  localparam int DATE_W  = 5;
  localparam int MON_W   = 4;
  localparam int NUM_AL  = 3;

  localparam logic [REG_AW-1:0] IX_SEC   = 4'd0;
  localparam logic [REG_AW-1:0] IX_MIN   = 4'd1;
  localparam logic [REG_AW-1:0] IX_HOUR  = 4'd2;
  localparam logic [REG_AW-1:0] IX_DOW   = 4'd3;
  localparam logic [REG_AW-1:0] IX_DATE  = 4'd4;
  localparam logic [REG_AW-1:0] IX_MON   = 4'd5;
  localparam logic [REG_AW-1:0] IX_YEAR  = 4'd6;
  localparam logic [REG_AW-1:0] IX_AL0   = 4'd7;
  localparam logic [REG_AW-1:0] IX_LAST  = 4'd9;

  function automatic logic [BYTE_W-1:0] to_ext(input logic [VAL_W-1:0] v, input logic bin);
    logic [VAL_W-1:0] tens, ones;
    tens = v / 7'd10;
    ones = v - tens * 7'd10;
    return bin ? {1'b0, v} : {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [VAL_W-1:0] from_ext(input logic [BYTE_W-1:0] b, input logic bin);
    return bin ? b[6:0] : ({3'b000, b[7:4]} * 7'd10 + {3'b000, b[3:0]});
  endfunction

  function automatic logic [BYTE_W-1:0] hour_to_ext(input logic [HOUR_W-1:0] h,
                                                    input logic bin, input logic h24);
    logic [VAL_W-1:0] hh;
    logic [BYTE_W-1:0] b;
    if (h24) return to_ext({2'b00, h}, bin);
    hh = (h >= 5'd12) ? {2'b00, h - 5'd12} : {2'b00, h};
    if (hh == 7'd0) hh = 7'd12;
    b = to_ext(hh, bin);
    return {(h >= 5'd12), b[6:0]};
  endfunction

  function automatic logic [HOUR_W-1:0] hour_from_ext(input logic [BYTE_W-1:0] b,
                                                      input logic bin, input logic h24);
    logic [VAL_W-1:0] v;
    if (h24) return from_ext(b, bin)[HOUR_W-1:0];
    v = from_ext({1'b0, b[6:0]}, bin);
    if (v == 7'd12) v = 7'd0;
    return v[HOUR_W-1:0] + (b[7] ? 5'd12 : 5'd0);
  endfunction

  function automatic logic [DATE_W-1:0] month_len(input logic [MON_W-1:0] m,
                                                  input logic [VAL_W-1:0] y);
    case (m)
      4'd2:                       return (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:    return 5'd30;
      default:                    return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
#(
  parameter int YEAR_LAST = 99
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              dst_en,
  input  logic              ld_en,
  input  logic [REG_AW-1:0] ld_sel,
  input  logic [VAL_W-1:0]  ld_val,
  output logic [SEC_W-1:0]  sec,
  output logic [SEC_W-1:0]  min,
  output logic [HOUR_W-1:0] hour,
  output logic [DOW_W-1:0]  dow,
  output logic [DATE_W-1:0] date,
  output logic [MON_W-1:0]  mon,
  output logic [VAL_W-1:0]  year
);
  localparam logic [VAL_W-1:0] YL = VAL_W'(YEAR_LAST);

  logic [SEC_W-1:0]  n_sec, n_min;
  logic [HOUR_W-1:0] n_hour;
  logic [DOW_W-1:0]  n_dow;
  logic [DATE_W-1:0] n_date;
  logic [MON_W-1:0]  n_mon;
  logic [VAL_W-1:0]  n_year;
  logic fb_q, n_fb, day_adv, spring, fall;

  assign spring = dst_en && mon == 4'd4  && dow == 3'd1 && date <= 5'd7  && hour == 5'd1;
  assign fall   = dst_en && mon == 4'd10 && dow == 3'd1 && date >= 5'd25 && hour == 5'd1;

  always_comb begin
    n_sec = sec; n_min = min; n_hour = hour; n_dow = dow;
    n_date = date; n_mon = mon; n_year = year; n_fb = fb_q; day_adv = 1'b0;
    if (ld_en) begin
      case (ld_sel)
        IX_SEC:  n_sec  = ld_val[SEC_W-1:0];
        IX_MIN:  n_min  = ld_val[SEC_W-1:0];
        IX_HOUR: n_hour = ld_val[HOUR_W-1:0];
        IX_DOW:  n_dow  = ld_val[DOW_W-1:0];
        IX_DATE: n_date = ld_val[DATE_W-1:0];
        IX_MON:  n_mon  = ld_val[MON_W-1:0];
        IX_YEAR: n_year = ld_val;
        default: ;
      endcase
    end else if (step) begin
      if (sec != 6'd59) n_sec = sec + 6'd1;
      else begin
        n_sec = '0;
        if (min != 6'd59) n_min = min + 6'd1;
        else begin
          n_min = '0;
          if (spring)                n_hour = 5'd3;
          else if (fall && !fb_q) begin n_hour = 5'd1; n_fb = 1'b1; end
          else if (hour == 5'd23) begin n_hour = '0; day_adv = 1'b1; end
          else                       n_hour = hour + 5'd1;
        end
      end
      if (day_adv) begin
        n_fb  = 1'b0;
        n_dow = (dow == 3'd7) ? 3'd1 : dow + 3'd1;
        if (date >= month_len(mon, year)) begin
          n_date = 5'd1;
          if (mon == 4'd12) begin
            n_mon  = 4'd1;
            n_year = (year >= YL) ? '0 : year + 7'd1;
          end else n_mon = mon + 4'd1;
        end else n_date = date + 5'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec <= '0; min <= '0; hour <= '0; dow <= 3'd1;
      date <= 5'd1; mon <= 4'd1; year <= '0; fb_q <= 1'b0;
    end else begin
      sec <= n_sec; min <= n_min; hour <= n_hour; dow <= n_dow;
      date <= n_date; mon <= n_mon; year <= n_year; fb_q <= n_fb;
    end
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_cal_pkg::*;
#(
  parameter int FIELDS = NUM_AL
) (
  input  logic [FIELDS-1:0][BYTE_W-1:0] cur,
  input  logic [FIELDS-1:0][BYTE_W-1:0] alm,
  output logic                          match
);
  logic [FIELDS-1:0] ok;
  for (genvar i = 0; i < FIELDS; i++) begin : g_field
    assign ok[i] = (alm[i][7:6] == 2'b11) || (alm[i] == cur[i]);
  end
  assign match = &ok;
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int YEAR_LAST = 99
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1s,
  input  logic              set_inhibit,
  input  logic              data_binary,
  input  logic              hour24,
  input  logic              dst_en,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              update_done,
  output logic              alarm_hit
);
  logic [SEC_W-1:0]  t_sec, t_min;
  logic [HOUR_W-1:0] t_hour;
  logic [DOW_W-1:0]  t_dow;
  logic [DATE_W-1:0] t_date;
  logic [MON_W-1:0]  t_mon;
  logic [VAL_W-1:0]  t_year;
  logic [NUM_AL-1:0][BYTE_W-1:0] al_q, cur_b;
  logic [VAL_W-1:0] ld_val;
  logic step, ld_en, upd_q, match;

  assign step  = tick_1s && !set_inhibit && !wr_en;
  assign ld_en = wr_en && (wr_addr <= IX_YEAR);
  assign ld_val = (wr_addr == IX_HOUR) ? {2'b00, hour_from_ext(wr_data, data_binary, hour24)}
                                       : from_ext(wr_data, data_binary);

  rtc_time_chain #(.YEAR_LAST(YEAR_LAST)) u_chain (
    .clk(clk), .rst_n(rst_n), .step(step), .dst_en(dst_en),
    .ld_en(ld_en), .ld_sel(wr_addr), .ld_val(ld_val),
    .sec(t_sec), .min(t_min), .hour(t_hour), .dow(t_dow),
    .date(t_date), .mon(t_mon), .year(t_year)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      al_q  <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= step;
      if (wr_en && wr_addr >= IX_AL0 && wr_addr <= IX_LAST)
        al_q[wr_addr - IX_AL0] <= wr_data;
    end
  end

  assign cur_b[0] = to_ext({1'b0, t_sec}, data_binary);
  assign cur_b[1] = to_ext({1'b0, t_min}, data_binary);
  assign cur_b[2] = hour_to_ext(t_hour, data_binary, hour24);

  rtc_alarm_match #(.FIELDS(NUM_AL)) u_alarm (.cur(cur_b), .alm(al_q), .match(match));

  assign update_done = upd_q;
  assign alarm_hit   = upd_q && match;

  always_comb begin
    case (rd_addr)
      IX_SEC:  rd_data = cur_b[0];
      IX_MIN:  rd_data = cur_b[1];
      IX_HOUR: rd_data = cur_b[2];
      IX_DOW:  rd_data = to_ext({4'b0, t_dow}, data_binary);
      IX_DATE: rd_data = to_ext({2'b0, t_date}, data_binary);
      IX_MON:  rd_data = to_ext({3'b0, t_mon}, data_binary);
      IX_YEAR: rd_data = to_ext(t_year, data_binary);
      4'd7:    rd_data = al_q[0];
      4'd8:    rd_data = al_q[1];
      4'd9:    rd_data = al_q[2];
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_1s,
  input logic       set_inhibit,
  input logic       wr_en,
  input logic       update_done,
  input logic       alarm_hit,
  input logic [5:0] sec,
  input logic [5:0] min,
  input logic [4:0] hour
);
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1s && !set_inhibit && !wr_en && sec != 6'd59) |=> (sec == $past(sec) + 6'd1)); // R1
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1s && !set_inhibit && !wr_en && sec == 6'd59) |=> (sec == 6'd0)); // R1
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (set_inhibit && !wr_en) |=> ($stable(sec) && $stable(min) && $stable(hour))); // R6
  AST_UPD_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1s && !set_inhibit && !wr_en) |=> update_done); // R7
  AST_NO_STRAY_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_1s && !set_inhibit && !wr_en) |=> !update_done); // R7
  AST_ALARM_WITH_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |-> update_done); // R8
endmodule

bind rtc_calendar_core rtc_calendar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .set_inhibit(set_inhibit),
  .wr_en(wr_en), .update_done(update_done), .alarm_hit(alarm_hit),
  .sec(t_sec), .min(t_min), .hour(t_hour)
);

// File: tb/sim_rtc_calendar_core.sv
module sim_rtc_calendar_core;
  logic clk = 1'b0, rst_n = 1'b0, tick_1s = 1'b0, set_inhibit = 1'b0;
  logic data_binary = 1'b0, hour24 = 1'b1, dst_en = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic update_done, alarm_hit;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rtc_calendar_core u0 (.*);

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    rd_addr = a; #1; chk(tag, rd_data, exp);
  endtask

  task automatic tick();
    @(negedge clk); tick_1s = 1'b1;
    @(negedge clk); tick_1s = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(4'd2, h); wr(4'd1, m); wr(4'd0, s);
  endtask

  task automatic t_reset();
    rd_chk("R10 sec", 4'd0, 8'h00); rd_chk("R10 hour", 4'd2, 8'h00);
    rd_chk("R10 dow", 4'd3, 8'h01); rd_chk("R10 date", 4'd4, 8'h01);
    rd_chk("R10 mon", 4'd5, 8'h01); rd_chk("R10 year", 4'd6, 8'h00);
    rd_chk("R10 alarm", 4'd9, 8'h00);
    chk("R10 upd", {7'b0, update_done}, 8'h00); chk("R10 alm", {7'b0, alarm_hit}, 8'h00);
  endtask

  task automatic t_rollover();
    wr(4'd3, 8'h07); wr(4'd4, 8'h31); wr(4'd5, 8'h12); wr(4'd6, 8'h99);
    set_time(8'h23, 8'h59, 8'h59);
    tick();
    chk("R7 upd pulse", {7'b0, update_done}, 8'h01);
    rd_chk("R1 sec", 4'd0, 8'h00); rd_chk("R1 min", 4'd1, 8'h00); rd_chk("R1 hour", 4'd2, 8'h00);
    rd_chk("R2 dow", 4'd3, 8'h01); rd_chk("R2 date", 4'd4, 8'h01);
    rd_chk("R2 mon", 4'd5, 8'h01); rd_chk("R2 year", 4'd6, 8'h00);
    @(negedge clk);
    chk("R7 upd one cycle", {7'b0, update_done}, 8'h00);
  endtask

  task automatic t_leap();
    wr(4'd6, 8'h24); wr(4'd5, 8'h02); wr(4'd4, 8'h28);
    set_time(8'h23, 8'h59, 8'h59); tick();
    rd_chk("R3 leap 29", 4'd4, 8'h29); rd_chk("R3 leap month", 4'd5, 8'h02);
    set_time(8'h23, 8'h59, 8'h59); tick();
    rd_chk("R3 leap to Mar", 4'd5, 8'h03); rd_chk("R3 leap date", 4'd4, 8'h01);
    wr(4'd6, 8'h23); wr(4'd5, 8'h02); wr(4'd4, 8'h28);
    set_time(8'h23, 8'h59, 8'h59); tick();
    rd_chk("R3 common Mar", 4'd5, 8'h03); rd_chk("R3 common date", 4'd4, 8'h01);
  endtask

  task automatic t_binary();
    @(negedge clk); data_binary = 1'b1;
    wr(4'd0, 8'h2D);
    rd_chk("R4 bin sec", 4'd0, 8'h2D);
    @(negedge clk); data_binary = 1'b0;
    rd_chk("R4 bcd sec", 4'd0, 8'h45);
    @(negedge clk); data_binary = 1'b1;
    wr(4'd8, 8'h0B);
    rd_chk("R4 bin alarm raw", 4'd8, 8'h0B);
    @(negedge clk); data_binary = 1'b0;
  endtask

  task automatic t_12h();
    wr(4'd4, 8'h05); wr(4'd5, 8'h03); wr(4'd6, 8'h21);
    @(negedge clk); hour24 = 1'b0;
    wr(4'd2, 8'h92);
    @(negedge clk); hour24 = 1'b1;
    rd_chk("R5 noon in 24h", 4'd2, 8'h12);
    wr(4'd2, 8'h13);
    @(negedge clk); hour24 = 1'b0;
    rd_chk("R5 13h as PM 1", 4'd2, 8'h81);
    set_time(8'h91, 8'h59, 8'h59); tick();
    rd_chk("R5 midnight 12 AM", 4'd2, 8'h12);
    rd_chk("R5 date advanced", 4'd4, 8'h06);
    @(negedge clk); hour24 = 1'b1;
    rd_chk("R5 midnight 24h", 4'd2, 8'h00);
  endtask

  task automatic t_inhibit();
    wr(4'd0, 8'h20);
    @(negedge clk); set_inhibit = 1'b1;
    tick();
    chk("R6 no pulse", {7'b0, update_done}, 8'h00);
    rd_chk("R6 frozen", 4'd0, 8'h20);
    @(negedge clk); set_inhibit = 1'b0;
    @(negedge clk); wr_en = 1'b1; wr_addr = 4'd0; wr_data = 8'h10; tick_1s = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick_1s = 1'b0;
    chk("R6 write wins no pulse", {7'b0, update_done}, 8'h00);
    rd_chk("R6 written value", 4'd0, 8'h10);
  endtask

  task automatic t_alarm();
    wr(4'd7, 8'h30); wr(4'd8, 8'hC0); wr(4'd9, 8'hC0);
    set_time(8'h10, 8'h15, 8'h29); tick();
    chk("R8 hit", {7'b0, alarm_hit}, 8'h01);
    chk("R8 hit with upd", {7'b0, update_done}, 8'h01);
    tick();
    chk("R8 no hit 31", {7'b0, alarm_hit}, 8'h00);
    wr(4'd9, 8'h05);
    set_time(8'h10, 8'h15, 8'h29); tick();
    chk("R8 hour mismatch", {7'b0, alarm_hit}, 8'h00);
    wr(4'd9, 8'h10); wr(4'd0, 8'h29); tick();
    chk("R8 exact match", {7'b0, alarm_hit}, 8'h01);
    wr(4'd7, 8'hC0); wr(4'd8, 8'hC0); wr(4'd9, 8'hC0);
  endtask

  task automatic t_dst();
    @(negedge clk); dst_en = 1'b1;
    wr(4'd5, 8'h04); wr(4'd4, 8'h02); wr(4'd3, 8'h01);
    set_time(8'h01, 8'h59, 8'h59); tick();
    rd_chk("R9 spring hour", 4'd2, 8'h03); rd_chk("R9 spring min", 4'd1, 8'h00);
    wr(4'd5, 8'h10); wr(4'd4, 8'h27); wr(4'd3, 8'h01);
    set_time(8'h01, 8'h59, 8'h59); tick();
    rd_chk("R9 fall back", 4'd2, 8'h01);
    wr(4'd1, 8'h59); wr(4'd0, 8'h59); tick();
    rd_chk("R9 fall once", 4'd2, 8'h02);
    @(negedge clk); dst_en = 1'b0;
    wr(4'd5, 8'h04); wr(4'd4, 8'h02); wr(4'd3, 8'h01);
    set_time(8'h01, 8'h59, 8'h59); tick();
    rd_chk("R9 disabled", 4'd2, 8'h02);
  endtask

  task automatic t_unused();
    rd_chk("R11 idx 10", 4'd10, 8'h00);
    rd_chk("R11 idx 15", 4'd15, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_rollover(); t_leap(); t_binary(); t_12h();
    t_inhibit(); t_alarm(); t_dst(); t_unused();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule